// File: doc/BRIEF.md
# Two-Word Jump Fetch Sequencer

This block is the fetch front end of a small processor with a 16-bit instruction stream and a 22-bit program counter. Each cycle it reads one word from program memory at the address it drives. Most instructions are one word long. For those, the sequencer latches the word into its instruction register and moves the program counter on by one.

The two absolute branch forms, jump and call, are two words long. The first word carries the opcode and the top six bits of the target. The second word is pure data and holds the low sixteen bits of the target. When the sequencer sees one of these, it spends one more cycle fetching the second word. During that cycle the first word stays in the instruction register. The sequencer then joins the two pieces and writes the result into the program counter. A call also raises a one-cycle request with the return address, for a return stack that sits outside this block.

All control lines come from combinational decode of the instruction register and the one-bit sequencing state. A low `ready` freezes the sequencer in whatever state it is in.

Top module: `fseq_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, `imem_addr` is 0, `ir` is 0, `busy` is 0 and `push_valid` and `pc_load` are 0. The first word is fetched from address 0 on the first clock edge after reset is released.
- R2: A single-word fetch takes one cycle. When `busy` is low and `ready` is high, `ir` loads `imem_rdata`, `imem_addr` advances by one and `busy` stays low.
- R3: A word is two-word only if bits [15:6] equal 10'h3D0 (jump) or 10'h3D1 (call). Every other value is single-word.
- R4: After a jump or call word is latched, `busy` is high for the second-word fetch. During that fetch `ir` keeps the first word, and after the fetch it still holds that word.
- R5: On the second-word cycle with `ready` high, the program counter loads {first word bits [5:0], second word [15:0]}, and `busy` falls.
- R6: `push_valid` is high only on the second-word cycle of a call with `ready` high, so it lasts one cycle. It is low for a jump. At that time `push_addr` equals the second word's address plus one, modulo 2^22.
- R7: When `ready` is low, `imem_addr`, `ir` and `busy` keep their values on the next edge, and `push_valid` and `pc_load` stay low. This holds in either state.
- R8: `dec_jump`, `dec_call` and `dec_two_word` decode `ir` with the R3 encoding. `pc_load` is high only on the second-word cycle with `ready` high.
- R9: The program counter wraps from 22'h3FFFFF to 0, both for sequential advance and for the return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ready | input | 1 | Memory word valid; low stalls the sequencer |
| imem_rdata | input | 16 | Program-memory word at `imem_addr` |
| imem_addr | output | 22 | Program counter, used as fetch address |
| ir | output | 16 | Instruction register |
| dec_jump | output | 1 | IR holds an absolute jump |
| dec_call | output | 1 | IR holds an absolute call |
| dec_two_word | output | 1 | IR holds a two-word instruction |
| pc_load | output | 1 | Joined target is written to the PC at this edge |
| busy | output | 1 | Second-word fetch in progress |
| push_valid | output | 1 | Return-address push request |
| push_addr | output | 22 | Return address for a call |

## Verification
The hardest case to reach is a call whose two words straddle the top of the address space, so that the return address must wrap to zero. The bench gets there by first issuing a jump whose joined target is 22'h3FFFFE, then a call at that address. It then jumps to 22'h3FFFFF and fetches a single word to see the counter wrap. Stalls are placed in both sequencing states. The stalled call cycle confirms that a held `ready` keeps `push_valid` from firing early or twice.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic {
        FSEQ_FETCH = 1'b0,
        FSEQ_OPER  = 1'b1
    } fseq_state_e;

    localparam int unsigned FSEQ_DEF_PC_W    = 22;
    localparam int unsigned FSEQ_DEF_IW      = 16;
    localparam int unsigned FSEQ_DEF_JMP_OP  = 'h3D0;
    localparam int unsigned FSEQ_DEF_CALL_OP = 'h3D1;

endpackage

// File: rtl/fseq_decode.sv
module fseq_decode #(
    parameter int unsigned OP_W    = 10,
    parameter int unsigned JMP_OP  = fseq_pkg::FSEQ_DEF_JMP_OP,
    parameter int unsigned CALL_OP = fseq_pkg::FSEQ_DEF_CALL_OP
) (
    input  logic [OP_W-1:0] op,
    output logic            is_jump,
    output logic            is_call
);
    localparam logic [OP_W-1:0] JMP_CODE  = OP_W'(JMP_OP);
    localparam logic [OP_W-1:0] CALL_CODE = OP_W'(CALL_OP);

    always_comb begin
        is_jump = (op == JMP_CODE);
        is_call = (op == CALL_CODE);
    end
endmodule

// File: rtl/fseq_addr.sv
module fseq_addr #(
    parameter int unsigned PC_W = 22,
    parameter int unsigned IW   = 16
) (
    input  logic [PC_W-1:0]    pc,
    input  logic [PC_W-IW-1:0] hi_part,
    input  logic [IW-1:0]      lo_part,
    output logic [PC_W-1:0]    pc_inc,
    output logic [PC_W-1:0]    target
);
    always_comb begin
        pc_inc = pc + PC_W'(1);
        target = {hi_part, lo_part};
    end
endmodule

// File: rtl/fseq_core.sv
module fseq_core #(
    parameter int unsigned PC_W    = fseq_pkg::FSEQ_DEF_PC_W,
    parameter int unsigned IW      = fseq_pkg::FSEQ_DEF_IW,
    parameter int unsigned JMP_OP  = fseq_pkg::FSEQ_DEF_JMP_OP,
    parameter int unsigned CALL_OP = fseq_pkg::FSEQ_DEF_CALL_OP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ready,
    input  logic [IW-1:0]   imem_rdata,
    output logic [PC_W-1:0] imem_addr,
    output logic [IW-1:0]   ir,
    output logic            dec_jump,
    output logic            dec_call,
    output logic            dec_two_word,
    output logic            pc_load,
    output logic            busy,
    output logic            push_valid,
    output logic [PC_W-1:0] push_addr
);
    import fseq_pkg::*;

    localparam int unsigned HI_W = PC_W - IW;
    localparam int unsigned OP_W = IW - HI_W;

    typedef struct packed {
        fseq_state_e     st;
        logic [PC_W-1:0] pc;
        logic [IW-1:0]   ir;
    } fseq_regs_t;

    fseq_regs_t regs_d, regs_q;

    logic            rd_jump, rd_call;
    logic            ir_jump, ir_call;
    logic [PC_W-1:0] pc_inc, target;

    // Decode of the incoming word (fetch state) and of the held word (control).
    fseq_decode #(.OP_W(OP_W), .JMP_OP(JMP_OP), .CALL_OP(CALL_OP)) u_dec_rd (
        .op      (imem_rdata[IW-1:HI_W]),
        .is_jump (rd_jump),
        .is_call (rd_call)
    );

    fseq_decode #(.OP_W(OP_W), .JMP_OP(JMP_OP), .CALL_OP(CALL_OP)) u_dec_ir (
        .op      (regs_q.ir[IW-1:HI_W]),
        .is_jump (ir_jump),
        .is_call (ir_call)
    );

    fseq_addr #(.PC_W(PC_W), .IW(IW)) u_addr (
        .pc      (regs_q.pc),
        .hi_part (regs_q.ir[HI_W-1:0]),
        .lo_part (imem_rdata),
        .pc_inc  (pc_inc),
        .target  (target)
    );

    always_comb begin
        regs_d     = regs_q;
        pc_load    = 1'b0;
        push_valid = 1'b0;
        case (regs_q.st)
            FSEQ_FETCH: begin
                if (ready) begin
                    regs_d.ir = imem_rdata;
                    regs_d.pc = pc_inc;
                    if (rd_jump || rd_call) begin
                        regs_d.st = FSEQ_OPER;
                    end
                end
            end
            FSEQ_OPER: begin
                if (ready) begin
                    regs_d.pc  = target;
                    regs_d.st  = FSEQ_FETCH;
                    pc_load    = 1'b1;
                    push_valid = ir_call;
                end
            end
            default: regs_d.st = FSEQ_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.st <= FSEQ_FETCH;
            regs_q.pc <= '0;
            regs_q.ir <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        imem_addr    = regs_q.pc;
        ir           = regs_q.ir;
        busy         = (regs_q.st == FSEQ_OPER);
        dec_jump     = ir_jump;
        dec_call     = ir_call;
        dec_two_word = ir_jump | ir_call;
        push_addr    = pc_inc;
    end
endmodule

// File: rtl/fseq_core_chk.sv
module fseq_core_chk #(
    parameter int unsigned PC_W    = 22,
    parameter int unsigned IW      = 16,
    parameter int unsigned JMP_OP  = 'h3D0,
    parameter int unsigned CALL_OP = 'h3D1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ready,
    input logic [IW-1:0]   imem_rdata,
    input logic [PC_W-1:0] imem_addr,
    input logic [IW-1:0]   ir,
    input logic            dec_jump,
    input logic            dec_call,
    input logic            dec_two_word,
    input logic            pc_load,
    input logic            busy,
    input logic            push_valid,
    input logic [PC_W-1:0] push_addr
);
    localparam int unsigned HI_W = PC_W - IW;
    localparam int unsigned OP_W = IW - HI_W;

    logic rd_two;
    assign rd_two = (imem_rdata[IW-1:HI_W] == OP_W'(JMP_OP)) ||
                    (imem_rdata[IW-1:HI_W] == OP_W'(CALL_OP));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ready && !rd_two) |=> (!busy && imem_addr == $past(imem_addr) + PC_W'(1)));

    assert_oper_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ready) |=> !busy);

    assert_ir_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ir));

    assert_target_join_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ready) |=> imem_addr == {$past(ir[HI_W-1:0]), $past(imem_rdata)});

    assert_push_call_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> (busy && ready && dec_call && push_addr == imem_addr + PC_W'(1)));

    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(imem_addr) && $stable(ir) && $stable(busy)));

    assert_load_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (busy && ready && dec_two_word));

    assert_decode_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_jump && dec_call));
endmodule

bind fseq_core fseq_core_chk #(
    .PC_W(PC_W), .IW(IW), .JMP_OP(JMP_OP), .CALL_OP(CALL_OP)
) u_chk (.*);

// File: tb/fseq_core_bench.sv
module fseq_core_bench;
    localparam int PC_W = 22;
    localparam int IW   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ready = 1'b0;
    logic [IW-1:0]   imem_rdata = '0;
    logic [PC_W-1:0] imem_addr, push_addr;
    logic [IW-1:0]   ir;
    logic            dec_jump, dec_call, dec_two_word, pc_load, busy, push_valid;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [PC_W-1:0] exp_pc = '0;
    logic [IW-1:0]   exp_ir = '0;

    always #5 clk = ~clk;

    fseq_core u_fseq_core (
        .clk(clk), .rst_n(rst_n), .ready(ready), .imem_rdata(imem_rdata),
        .imem_addr(imem_addr), .ir(ir), .dec_jump(dec_jump), .dec_call(dec_call),
        .dec_two_word(dec_two_word), .pc_load(pc_load), .busy(busy),
        .push_valid(push_valid), .push_addr(push_addr)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    function automatic int kind_of(input logic [IW-1:0] w);
        // R3: 0 single, 1 jump, 2 call
        if (w[15:6] == 10'h3D0) return 1;
        if (w[15:6] == 10'h3D1) return 2;
        return 0;
    endfunction

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Executes one instruction; entered and left just after a falling edge.
    task automatic run_word(input logic [IW-1:0] w, input logic [IW-1:0] lo,
                            input bit stall_f, input bit stall_o, input string tag);
        int k;
        logic [PC_W-1:0] ret;
        k = kind_of(w);
        chk(imem_addr == exp_pc, {tag, " R2 fetch addr"}, imem_addr, exp_pc);
        if (stall_f) begin
            imem_rdata = w; ready = 1'b0;
            cycle();
            chk(imem_addr == exp_pc && ir == exp_ir && !busy, "R7 fetch stall", {imem_addr, ir}, {exp_pc, exp_ir});
        end
        imem_rdata = w; ready = 1'b1;
        cycle();
        exp_ir = w;
        exp_pc = exp_pc + 22'd1;
        chk(ir == w, "R2 ir load", ir, w);
        chk(imem_addr == exp_pc, "R9 R2 pc advance", imem_addr, exp_pc);
        chk(busy == (k != 0), "R3 R4 busy after first word", busy, k != 0);
        chk(dec_two_word == (k != 0) && dec_jump == (k == 1) && dec_call == (k == 2),
            "R8 decode lines", {dec_jump, dec_call, dec_two_word}, k);
        if (k != 0) begin
            if (stall_o) begin
                imem_rdata = lo; ready = 1'b0;
                #1;
                chk(!push_valid && !pc_load, "R7 no push or load on stall", {push_valid, pc_load}, 0);
                cycle();
                chk(busy && imem_addr == exp_pc && ir == w, "R7 oper stall", {busy, imem_addr}, {1'b1, exp_pc});
            end
            imem_rdata = lo; ready = 1'b1;
            #1;
            ret = exp_pc + 22'd1;
            chk(pc_load, "R8 pc_load strobe", pc_load, 1);
            chk(push_valid == (k == 2), "R6 push only for call", push_valid, k == 2);
            if (k == 2) chk(push_addr == ret, "R6 R9 return address", push_addr, ret);
            cycle();
            exp_pc = {w[5:0], lo};
            chk(imem_addr == exp_pc, "R5 joined target", imem_addr, exp_pc);
            chk(!busy && ir == w, "R4 busy falls, ir held", {busy, ir}, {1'b0, w});
            chk(!push_valid && !pc_load, "R6 single-cycle push", {push_valid, pc_load}, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        ready = 1'b1;
        imem_rdata = 16'hF400;
        repeat (3) cycle();
        chk(imem_addr == 0 && ir == 0 && !busy && !push_valid && !pc_load, "R1 in reset",
            {imem_addr, ir, busy}, 0);
        rst_n = 1'b1;
        #1;
        chk(imem_addr == 0 && ir == 0 && !busy, "R1 after release", {imem_addr, ir}, 0);

        // Upper-byte sweep: every opcode neighbourhood, both stall places.
        for (int b = 0; b < 256; b++) begin
            for (int m = 0; m < 4; m++) begin
                logic [IW-1:0] w;
                w = {b[7:0], m[1:0], 6'(b * 7 + m)};
                run_word(w, 16'(b * 257 ^ 16'h1234 ^ m), b[0], m[0], "R3 sweep");
            end
        end

        // Every high-part value, for jump and call, several low words.
        for (int h = 0; h < 64; h++) begin
            for (int c = 0; c < 2; c++) begin
                for (int s = 0; s < 3; s++) begin
                    logic [IW-1:0] lo;
                    lo = (s == 0) ? 16'h0000 : (s == 1) ? 16'hFFFF : 16'(h * 1021);
                    run_word({9'h1E8, c[0], h[5:0]}, lo, (h % 3) == 0, s == 1, "R5 sweep");
                    run_word(16'(h * 97 + s), 16'h0, 1'b0, 1'b0, "R2 after branch");
                end
            end
        end

        // Wrap corners: call straddling the top, then sequential wrap.
        run_word({10'h3D0, 6'h3F}, 16'hFFFE, 1'b0, 1'b0, "R9 jump top");
        run_word({10'h3D1, 6'h05}, 16'hABCD, 1'b0, 1'b1, "R9 call at top");
        run_word({10'h3D0, 6'h3F}, 16'hFFFF, 1'b1, 1'b0, "R9 jump last");
        run_word(16'h0123, 16'h0, 1'b0, 1'b0, "R9 seq wrap");
        chk(imem_addr == 0, "R9 pc wrapped to zero", imem_addr, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule